// File: doc/BRIEF.md
# Phase-Linked Sampling Window Generator

This block is a cycle-level model of the sampling-clock stage of a divider-less, reference-sampled fractional synthesizer. A fast clock stands in for the oscillator phase slots, and a reference period is `PERIOD` consecutive fast cycles. Each period an index from the fractional sequencer names which of the `NPH` interpolated positions carries the three adjacent phases used for sampling. The phases fall in slots `idx`, `idx+1` and `idx+2` of the period.

A set/clear window register follows the selected triplet. The first phase opens the window when the positive-side enable is high. The third phase closes it when the negative-side enable is high. The single sampling pulse is the middle phase gated by that window, so the mask moves with the chosen phase and never cuts a pulse short.

Successive sampling events go to two sampling capacitors in turn. Two complementary hold strobes tell the differential detector which capacitor currently feeds the loop filter.

Top module: `phase_window_sampler`

## Requirements
- R1: While reset is asserted and on its release: holdP=1, holdN=0, sampP=0, sampN=0, sampPulse=0, window=0.
- R2: A reference period is PERIOD fast cycles, with slots 0..PERIOD-1 counted from reset release. selIdx is captured at the clock edge that ends slot PERIOD-1 and applies to the following period. The first period after reset uses index 0. The phase slots are idx, idx+1 and idx+2.
- R3: With the window closed and posEn high during slot idx, the window is low in slot idx and high from slot idx+1.
- R4: With negEn high during slot idx+2, the window is low from slot idx+3. With negEn low, the window stays open past the period end.
- R5: For every index 0..31 with both enables high, exactly one sampPulse occurs in the period. It lasts one fast cycle and falls in slot idx+1.
- R6: No sampPulse, sampP or sampN occurs while the window is closed. If posEn is low and the window was closed, the period has no pulse.
- R7: The first pulse after reset appears on sampP (upper capacitor), the next on sampN (lower capacitor), and the two strictly alternate after that. At most one of them is high in any cycle.
- R8: holdP and holdN are always complementary. Both invert in the cycle after each sampling pulse.
- R9: A capacitor is never held while it samples: sampP excludes holdN, and sampN excludes holdP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one cycle per phase slot |
| rstN | input | 1 | Active-low synchronous reset |
| selIdx | input | 5 | Interpolated position of the triplet for the next period |
| posEn | input | 1 | Positive-side enable that allows the window to open |
| negEn | input | 1 | Negative-side enable that allows the window to close |
| window | output | 1 | Moving mask window |
| sampPulse | output | 1 | Middle phase gated by the window |
| sampP | output | 1 | Sample strobe, upper capacitor |
| sampN | output | 1 | Sample strobe, lower capacitor |
| holdP | output | 1 | Lower capacitor drives the filter |
| holdN | output | 1 | Upper capacitor drives the filter |

## Verification
A wrong slot counter or index register shows up within one period as a pulse in a slot other than idx+1. A window register that fails to clear shows up as a high window at the last slot of the period. A lost or doubled bank toggle shows up at the next pulse, which lands on the wrong capacitor, and at once as a hold pair that does not match the expected bank. The sweep over all 32 indices exposes any off-by-one in the phase decode at the period edges, including index 31, where the third phase lands two slots before the period wraps.

// File: rtl/swin_pkg.sv
package swin_pkg;
  // One-cycle phase strobes from control to datapath
  typedef struct packed {
    logic first;
    logic mid;
    logic last;
  } phaseStrobes_t;
endpackage

// File: rtl/swin_phase_ctrl.sv
module swin_phase_ctrl
  import swin_pkg::*;
#(
  parameter int PERIOD = 36,
  parameter int NPH    = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [$clog2(NPH)-1:0] selIdx,
  output phaseStrobes_t          strb
);
  localparam int SLOT_W = $clog2(PERIOD);
  localparam int IDX_W  = $clog2(NPH);

  logic [SLOT_W-1:0] slotQ;
  logic [IDX_W-1:0]  idxQ;
  logic [SLOT_W-1:0] baseSlot;

  // Slot counter and per-period index capture (R2)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= '0;
      idxQ  <= '0;
    end else if (slotQ == SLOT_W'(PERIOD - 1)) begin
      slotQ <= '0;
      idxQ  <= selIdx;
    end else begin
      slotQ <= slotQ + 1'b1;
    end
  end

  always_comb begin
    baseSlot   = SLOT_W'(idxQ);
    strb.first = (slotQ == baseSlot);
    strb.mid   = (slotQ == baseSlot + SLOT_W'(1));
    strb.last  = (slotQ == baseSlot + SLOT_W'(2));
  end
endmodule

// File: rtl/swin_sample_path.sv
module swin_sample_path
  import swin_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  phaseStrobes_t strb,
  input  logic          posEn,
  input  logic          negEn,
  output logic          window,
  output logic          sampPulse,
  output logic          sampP,
  output logic          sampN,
  output logic          holdP,
  output logic          holdN
);
  logic       winQ;
  logic       bankQ;
  logic [1:0] sampVec;
  logic [1:0] holdVec;

  // Window: set on the first phase, cleared on the third (R3, R4)
  always_ff @(posedge clk) begin
    if (!rstN)                     winQ <= 1'b0;
    else if (strb.last && negEn)   winQ <= 1'b0;
    else if (strb.first && posEn)  winQ <= 1'b1;
  end

  assign window    = winQ;
  assign sampPulse = winQ & strb.mid;

  // Bank pointer flips after each sampling event (R7, R8)
  always_ff @(posedge clk) begin
    if (!rstN)          bankQ <= 1'b0;
    else if (sampPulse) bankQ <= ~bankQ;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign sampVec[b] = sampPulse & (bankQ == 1'(b));
    assign holdVec[b] = (bankQ == 1'(b));
  end

  assign sampP = sampVec[0];
  assign sampN = sampVec[1];
  assign holdP = holdVec[0];
  assign holdN = holdVec[1];
endmodule

// File: rtl/phase_window_sampler.sv
module phase_window_sampler
  import swin_pkg::*;
#(
  parameter int PERIOD = 36,
  parameter int NPH    = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [$clog2(NPH)-1:0] selIdx,
  input  logic                   posEn,
  input  logic                   negEn,
  output logic                   window,
  output logic                   sampPulse,
  output logic                   sampP,
  output logic                   sampN,
  output logic                   holdP,
  output logic                   holdN
);
  phaseStrobes_t strb;

  swin_phase_ctrl #(.PERIOD(PERIOD), .NPH(NPH)) u_ctrl (
    .clk(clk), .rstN(rstN), .selIdx(selIdx), .strb(strb)
  );

  swin_sample_path u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .posEn(posEn), .negEn(negEn),
    .window(window), .sampPulse(sampPulse), .sampP(sampP), .sampN(sampN),
    .holdP(holdP), .holdN(holdN)
  );
endmodule

// File: rtl/swin_checker.sv
module swin_checker (
  input logic clk,
  input logic rstN,
  input logic posEn,
  input logic window,
  input logic sampPulse,
  input logic sampP,
  input logic sampN,
  input logic holdP,
  input logic holdN
);
  a_r8_hold_complement: assert property (@(posedge clk) disable iff (!rstN)
    holdP != holdN);

  a_r9_upper_not_held: assert property (@(posedge clk) disable iff (!rstN)
    sampP |-> !holdN);

  a_r9_lower_not_held: assert property (@(posedge clk) disable iff (!rstN)
    sampN |-> !holdP);

  a_r6_pulse_in_window: assert property (@(posedge clk) disable iff (!rstN)
    sampPulse |-> window);

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    sampPulse |=> !sampPulse);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampP, sampN}));

  a_r8_swap_after_upper: assert property (@(posedge clk) disable iff (!rstN)
    sampP |=> holdN);

  a_r8_swap_after_lower: assert property (@(posedge clk) disable iff (!rstN)
    sampN |=> holdP);

  a_r3_open_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(window) |-> $past(posEn));
endmodule

bind phase_window_sampler swin_checker u_chk (
  .clk(clk), .rstN(rstN), .posEn(posEn), .window(window),
  .sampPulse(sampPulse), .sampP(sampP), .sampN(sampN),
  .holdP(holdP), .holdN(holdN)
);

// File: tb/phase_window_sampler_tb.sv
module phase_window_sampler_tb;
  localparam int PERIOD = 36;
  localparam int NPH    = 32;
  localparam int NCORN  = 4;
  localparam int NV     = NPH + NCORN;

  typedef struct packed {
    logic [4:0] idx;
    logic       pos;
    logic       neg;
    logic       expCnt;
    logic       expWinEnd;
  } vec_t;

  // Corner periods after the sweep: closed window with posEn low,
  // a window left open, a stale open window, then a clean closed period
  localparam vec_t CORNER [NCORN] = '{
    '{idx: 5'd5,  pos: 1'b0, neg: 1'b1, expCnt: 1'b0, expWinEnd: 1'b0},
    '{idx: 5'd9,  pos: 1'b1, neg: 1'b0, expCnt: 1'b1, expWinEnd: 1'b1},
    '{idx: 5'd12, pos: 1'b0, neg: 1'b1, expCnt: 1'b1, expWinEnd: 1'b0},
    '{idx: 5'd12, pos: 1'b0, neg: 1'b1, expCnt: 1'b0, expWinEnd: 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] selIdx = '0;
  logic posEn = 1'b0;
  logic negEn = 1'b0;
  logic window, sampPulse, sampP, sampN, holdP, holdN;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  phase_window_sampler #(.PERIOD(PERIOD), .NPH(NPH)) u_dut (
    .clk(clk), .rstN(rstN), .selIdx(selIdx), .posEn(posEn), .negEn(negEn),
    .window(window), .sampPulse(sampPulse), .sampP(sampP), .sampN(sampN),
    .holdP(holdP), .holdN(holdN)
  );

  function automatic vec_t getVec(int p);
    vec_t v;
    if (p < NPH) begin
      v.idx = 5'(p); v.pos = 1'b1; v.neg = 1'b1;
      v.expCnt = 1'b1; v.expWinEnd = 1'b0;
    end else begin
      v = CORNER[p - NPH];
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t cur;
    vec_t nxt;
    int   cnt;
    bit   bankExp;

    // Reset state (R1)
    repeat (3) @(negedge clk);
    check(holdP == 1'b1 && holdN == 1'b0, "R1 holds in reset", {holdP, holdN}, 2);
    check(!sampP && !sampN && !sampPulse, "R1 strobes in reset", {sampPulse, sampP, sampN}, 0);
    check(window == 1'b0, "R1 window in reset", window, 0);

    cur = getVec(0);
    posEn = cur.pos; negEn = cur.neg; selIdx = cur.idx;
    bankExp = 1'b0;
    rstN = 1'b1;
    check(holdP == 1'b1 && holdN == 1'b0, "R1 holds after release", {holdP, holdN}, 2);

    for (int p = 0; p < NV; p++) begin
      cur = getVec(p);
      cnt = 0;
      for (int s = 0; s < PERIOD; s++) begin
        // sampled at negedge: slot s is on display
        check(holdP == !bankExp && holdN == bankExp, "R8 hold pair",
              {holdP, holdN}, {!bankExp, bankExp});
        if (sampPulse) begin
          cnt++;
          check(s == int'(cur.idx) + 1, "R5 pulse slot", s, int'(cur.idx) + 1);
          check(sampP == !bankExp && sampN == bankExp, "R7 capacitor order",
                {sampP, sampN}, {!bankExp, bankExp});
          check(window == 1'b1, "R6 pulse inside window", window, 1);
          bankExp = !bankExp;
        end else begin
          check(!sampP && !sampN, "R6 no strobe without pulse", {sampP, sampN}, 0);
        end
        if (p < NPH) begin
          if (s == int'(cur.idx))     check(window == 1'b0, "R3 window before first phase", window, 0);
          if (s == int'(cur.idx) + 2) check(window == 1'b1, "R3 window held open", window, 1);
          if (s == int'(cur.idx) + 3) check(window == 1'b0, "R4 window closed after third phase", window, 0);
        end
        if (s == PERIOD - 1)
          check(window == cur.expWinEnd, "R4 window at period end", window, cur.expWinEnd);
        if (s == 0) begin
          posEn = cur.pos;
          negEn = cur.neg;
          if (p + 1 < NV) begin
            nxt = getVec(p + 1);
            selIdx = nxt.idx;   // captured at end of this period (R2)
          end
        end
        @(negedge clk);
      end
      check(cnt == int'(cur.expCnt), "R5 R6 pulses per period", cnt, cur.expCnt);
    end

    // Reset mid-run returns to the initial bank (R1, R7)
    rstN = 1'b0;
    @(negedge clk);
    check(holdP == 1'b1 && holdN == 1'b0 && !window, "R1 reset mid-run",
          {holdP, holdN, window}, 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule